// File: doc/BRIEF.md
# Port Group Mask Forwarding Resolver

This block works out the egress port set of each frame in a small Layer-2 switch. It holds one table of port bitmasks, one bit for each physical port plus one bit for the CPU port. For every frame it reads three entries of that table and outputs their bitwise AND as the final destination mask.

The first entry is the destination group. On an address-table hit, this entry comes from the index that the hit supplies. On a miss, it is a flood entry chosen by frame class. The second entry is the aggregation group, selected by a 4-bit flow hash code. This entry keeps each flow on a single member of a link group. The third entry is the source group of the ingress port. It states which egress ports that ingress port may reach.

Software loads the table through a plain address, data and write-enable port and reads it back on the same port. Frames enter one per cycle. Each result leaves three register stages later, with a valid strobe and an error flag.

Top module: `pgmask_resolver`

## Requirements
- R1: After reset, every table entry reads zero and `res_valid`, `res_err`, `res_mask` and `cfg_rdata` are zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` on the clock edge. `cfg_rdata` shows the entry at `cfg_addr` one edge after the address is presented. Writes to addresses of 91 and above are dropped, and those addresses read as zero.
- R3: When `frm_hit` is 1, the destination entry index is `frm_dest_idx` (0 to 63).
- R4: When `frm_hit` is 0, `frm_dest_idx` is ignored and the destination entry is picked by `frm_class`. Class 0 (unknown unicast) uses entry 60. Class 1 (broadcast) and class 2 (non-IP multicast) use entry 61. Class 3 (IPv4 multicast) uses entry 62. Class 4 (IPv6 multicast) uses entry 63. Classes 5 to 7 use entry 61.
- R5: The aggregation entry index is 64 plus `frm_aggr`.
- R6: The source entry index is 80 plus `frm_port`. Bit j of entry 80+i allows port i to reach port j, and bit 11 (NPORTS) is the CPU port.
- R7: `res_mask` is the bitwise AND of the destination, aggregation and source entries.
- R8: A frame sampled with `frm_valid` high on an edge produces `res_valid` high after the third edge, counting that edge as the first. Frames may arrive on consecutive cycles, and their results come out in the same order.
- R9: A frame whose `frm_port` is NPORTS (11) or higher produces `res_err` high and an all-zero `res_mask`, with `res_valid` high.
- R10: A table write committed on the edge after a frame is sampled does not affect that frame's result, which uses the old contents. The next frame sees the new contents.
- R11: While `res_valid` is low, `res_mask` and `res_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 7 | Table entry address for write and read |
| cfg_wdata | input | 12 | Write data |
| cfg_rdata | output | 12 | Registered read data of entry at cfg_addr |
| frm_valid | input | 1 | Frame lookup request |
| frm_hit | input | 1 | Address table hit (1) or miss (0) |
| frm_dest_idx | input | 6 | Destination entry index from the address table |
| frm_class | input | 3 | Frame class used on a miss |
| frm_aggr | input | 4 | Flow aggregation code |
| frm_port | input | 4 | Ingress port number |
| res_valid | output | 1 | Result strobe |
| res_mask | output | 12 | Final egress port mask, CPU at bit 11 |
| res_err | output | 1 | Ingress port out of range |

## Verification
A stream of back-to-back frames crosses hit and miss lookups, every frame class and several aggregation codes and ingress ports. The table is loaded so that each of the three entries is, in some frame, the only one that clears bits. A wrong index in any one stage therefore changes a result. Hit frames aimed at the reserved flood entries and miss frames with a misleading `frm_dest_idx` show whether the hit/miss choice is made correctly. Directed cases cover out-of-range ingress ports, dropped writes above the table, the same-edge write against an in-flight read, and the exact cycle the strobe rises.

// File: rtl/pgmask_resolver.sv
module pgmask_resolver #(
  parameter int NPORTS    = 11,
  parameter int AGGR_BITS = 4
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             cfg_we,
  input  logic [$clog2(64 + (1 << AGGR_BITS) + NPORTS)-1:0] cfg_addr,
  input  logic [NPORTS:0]                                  cfg_wdata,
  output logic [NPORTS:0]                                  cfg_rdata,
  input  logic                                             frm_valid,
  input  logic                                             frm_hit,
  input  logic [5:0]                                       frm_dest_idx,
  input  logic [2:0]                                       frm_class,
  input  logic [AGGR_BITS-1:0]                             frm_aggr,
  input  logic [$clog2(NPORTS)-1:0]                        frm_port,
  output logic                                             res_valid,
  output logic [NPORTS:0]                                  res_mask,
  output logic                                             res_err
);
  localparam int AGGR_BASE = 64;
  localparam int SRC_BASE  = AGGR_BASE + (1 << AGGR_BITS);
  localparam int DEPTH     = SRC_BASE + NPORTS;
  localparam int W         = NPORTS + 1;
  localparam int AW        = $clog2(DEPTH);
  localparam int PW        = $clog2(NPORTS);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [PW-1:0] LAST_PORT = PW'(NPORTS - 1);
  localparam logic [5:0] FLOOD_UC   = 6'd60;
  localparam logic [5:0] FLOOD_BC   = 6'd61;
  localparam logic [5:0] FLOOD_IPV4 = 6'd62;
  localparam logic [5:0] FLOOD_IPV6 = 6'd63;

  logic [W-1:0] tab [DEPTH];

  logic [5:0] flood_idx;
  logic [5:0] dst_idx;
  logic       port_ok;

  always_comb begin
    case (frm_class)
      3'd0:    flood_idx = FLOOD_UC;
      3'd3:    flood_idx = FLOOD_IPV4;
      3'd4:    flood_idx = FLOOD_IPV6;
      default: flood_idx = FLOOD_BC;
    endcase
  end

  assign dst_idx = frm_hit ? frm_dest_idx : flood_idx;
  assign port_ok = frm_port <= LAST_PORT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
    end else if (cfg_we && cfg_addr <= LAST_ADDR) begin
      tab[cfg_addr] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rdata <= '0;
    else        cfg_rdata <= (cfg_addr <= LAST_ADDR) ? tab[cfg_addr] : '0;
  end

  logic          s1_v, s1_err;
  logic [5:0]    s1_dst;
  logic [AW-1:0] s1_agg, s1_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_err <= 1'b0;
      s1_dst <= '0;
      s1_agg <= '0;
      s1_src <= '0;
    end else begin
      s1_v   <= frm_valid;
      s1_err <= frm_valid & ~port_ok;
      s1_dst <= dst_idx;
      s1_agg <= AW'(AGGR_BASE) + AW'(frm_aggr);
      s1_src <= AW'(SRC_BASE) + (port_ok ? AW'(frm_port) : '0);
    end
  end

  logic         s2_v, s2_err;
  logic [W-1:0] m_dst, m_agg, m_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_err <= 1'b0;
      m_dst  <= '0;
      m_agg  <= '0;
      m_src  <= '0;
    end else begin
      s2_v   <= s1_v;
      s2_err <= s1_err;
      m_dst  <= tab[s1_dst];
      m_agg  <= tab[s1_agg];
      m_src  <= tab[s1_src];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_mask  <= '0;
    end else begin
      res_valid <= s2_v;
      res_err   <= s2_v & s2_err;
      res_mask  <= (s2_v && !s2_err) ? (m_dst & m_agg & m_src) : '0;
    end
  end
endmodule

module pgmask_resolver_chk #(
  parameter int NPORTS    = 11,
  parameter int AGGR_BITS = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        frm_valid,
  input logic [$clog2(NPORTS)-1:0]   frm_port,
  input logic                        res_valid,
  input logic [NPORTS:0]             res_mask,
  input logic                        res_err
);
  localparam logic [$clog2(NPORTS)-1:0] LAST_PORT = ($clog2(NPORTS))'(NPORTS - 1);

  logic [2:0] vsh, esh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsh <= '0;
      esh <= '0;
    end else begin
      vsh <= {vsh[1:0], frm_valid};
      esh <= {esh[1:0], frm_valid && (frm_port > LAST_PORT)};
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid == vsh[2]);

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) res_err == esh[2]);

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) res_err |-> res_mask == '0);

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == '0 && !res_err));
endmodule

bind pgmask_resolver pgmask_resolver_chk #(.NPORTS(NPORTS), .AGGR_BITS(AGGR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_port(frm_port),
  .res_valid(res_valid), .res_mask(res_mask), .res_err(res_err)
);

// File: tb/test_pgmask_resolver.sv
module test_pgmask_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] cfg_rdata;
  logic        frm_valid = 1'b0;
  logic        frm_hit = 1'b0;
  logic [5:0]  frm_dest_idx = '0;
  logic [2:0]  frm_class = '0;
  logic [3:0]  frm_aggr = '0;
  logic [3:0]  frm_port = '0;
  logic        res_valid;
  logic [11:0] res_mask;
  logic        res_err;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgmask_resolver i_pgmask_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frm_valid(frm_valid),
    .frm_hit(frm_hit), .frm_dest_idx(frm_dest_idx), .frm_class(frm_class),
    .frm_aggr(frm_aggr), .frm_port(frm_port), .res_valid(res_valid),
    .res_mask(res_mask), .res_err(res_err)
  );

  // {hit, dest_idx, class, aggr, port, expected mask}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 6'd3,  3'd0, 4'd0, 4'd0,  12'h008},  // R3 R7
    {1'b1, 6'd3,  3'd0, 4'd0, 4'd2,  12'h000},  // R6
    {1'b1, 6'd20, 3'd0, 4'd5, 4'd0,  12'h0A0},  // R5
    {1'b1, 6'd20, 3'd0, 4'd0, 4'd6,  12'h030},  // R6
    {1'b0, 6'd3,  3'd0, 4'd9, 4'd0,  12'hF0F},  // R4 unicast flood
    {1'b0, 6'd3,  3'd1, 4'd0, 4'd6,  12'h03F},  // R4 broadcast
    {1'b0, 6'd20, 3'd2, 4'd5, 4'd0,  12'h0AA},  // R4 non-IP multicast
    {1'b0, 6'd3,  3'd3, 4'd9, 4'd2,  12'h007},  // R4 IPv4
    {1'b0, 6'd3,  3'd4, 4'd0, 4'd6,  12'hE00},  // R4 IPv6
    {1'b1, 6'd59, 3'd4, 4'd0, 4'd0,  12'h800},  // R3 CPU entry
    {1'b1, 6'd63, 3'd0, 4'd9, 4'd10, 12'hF00},  // R3 R7
    {1'b1, 6'd10, 3'd0, 4'd0, 4'd0,  12'h000},  // R3 empty entry
    {1'b0, 6'd20, 3'd6, 4'd5, 4'd10, 12'h0AA}   // R4 spare class
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [6:0] a, output logic [11:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic drive(input logic v, input logic h, input logic [5:0] di,
                       input logic [2:0] c, input logic [3:0] ag, input logic [3:0] p);
    frm_valid = v; frm_hit = h; frm_dest_idx = di;
    frm_class = c; frm_aggr = ag; frm_port = p;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [11:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 res_err", {31'd0, res_err}, 32'd0);
    chk("R1 res_mask", {20'd0, res_mask}, 32'd0);
    cfg_read(7'd60, rd);
    chk("R1 entry 60", {20'd0, rd}, 32'd0);
    cfg_read(7'd90, rd);
    chk("R1 entry 90", {20'd0, rd}, 32'd0);

    for (int i = 64; i < 91; i++) cfg_write(7'(i), 12'hFFF);
    cfg_write(7'd3,  12'h008);
    cfg_write(7'd20, 12'h0F0);
    cfg_write(7'd59, 12'h800);
    cfg_write(7'd60, 12'hFFF);
    cfg_write(7'd61, 12'h0FF);
    cfg_write(7'd62, 12'h00F);
    cfg_write(7'd63, 12'hF00);
    cfg_write(7'd69, 12'h0AA);
    cfg_write(7'd73, 12'hF0F);
    cfg_write(7'd82, 12'hFF7);
    cfg_write(7'd86, 12'hE3F);

    cfg_read(7'd61, rd);
    chk("R2 readback 61", {20'd0, rd}, 32'h0FF);
    cfg_read(7'd86, rd);
    chk("R2 readback 86", {20'd0, rd}, 32'hE3F);
    cfg_write(7'd100, 12'hABC);
    cfg_read(7'd100, rd);
    chk("R2 out of range read", {20'd0, rd}, 32'd0);

    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        chk("R8 valid in stream", {31'd0, res_valid}, 32'd1);
        chk("R7 stream mask", {20'd0, res_mask}, {20'd0, VEC[j-3][11:0]});
      end
      if (j < NV)
        drive(1'b1, VEC[j][29], VEC[j][28:23], VEC[j][22:20], VEC[j][19:16], VEC[j][15:12]);
      else
        frm_valid = 1'b0;
    end
    @(negedge clk);
    chk("R11 idle valid", {31'd0, res_valid}, 32'd0);
    chk("R11 idle mask", {20'd0, res_mask}, 32'd0);

    drive(1'b1, 1'b1, 6'd60, 3'd0, 4'd0, 4'd0);
    @(negedge clk);
    frm_valid = 1'b0;
    chk("R8 not valid after 1 edge", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    chk("R8 not valid after 2 edges", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    chk("R8 valid after 3 edges", {31'd0, res_valid}, 32'd1);
    chk("R8 mask", {20'd0, res_mask}, 32'hFFF);

    drive(1'b1, 1'b1, 6'd60, 3'd0, 4'd0, 4'd11);
    @(negedge clk); frm_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 err port 11", {31'd0, res_err}, 32'd1);
    chk("R9 mask port 11", {20'd0, res_mask}, 32'd0);
    chk("R9 valid port 11", {31'd0, res_valid}, 32'd1);
    drive(1'b1, 1'b1, 6'd60, 3'd0, 4'd0, 4'd15);
    @(negedge clk); frm_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 err port 15", {31'd0, res_err}, 32'd1);
    chk("R9 mask port 15", {20'd0, res_mask}, 32'd0);

    drive(1'b1, 1'b1, 6'd3, 3'd0, 4'd0, 4'd0);
    @(negedge clk);
    frm_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 7'd3; cfg_wdata = 12'hFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R10 old contents", {20'd0, res_mask}, 32'h008);
    drive(1'b1, 1'b1, 6'd3, 3'd0, 4'd0, 4'd0);
    @(negedge clk); frm_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 new contents", {20'd0, res_mask}, 32'hFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule